// File: doc/BRIEF.md
# Trigger and Bunch Identifier Counters

This block produces the identifiers a trigger system attaches to every accepted trigger. A 24-bit trigger number advances on each trigger and an 8-bit event-counter-reset (ECR) count advances on each ECR. A free-running 12-bit bunch-crossing counter is cleared by a bunch-counter reset (BCR). On each trigger the block captures the bunch crossing, corrected by a programmable 12-bit offset, into a readable register. The trigger number itself is the "last trigger" value, so it starts at all-ones and the first trigger after reset or ECR reads as zero.

A simple host port writes and reads 16-bit words. The offset and the mode bits may be written at any time. The identifier words may be loaded only while run mode is low, so a running system cannot disturb its own numbering. Two mode bits select the bunch period (3564 or 4096 crossings) and allow a wrap of the trigger number to advance the ECR count, which turns the pair into one 32-bit identifier.

Top module: `tbid_top`

## Requirements
- R1: After reset the trigger number is 0xFFFFFF, the ECR count is 0, the captured bunch number is 0, the offset is 0 and both mode bits are 0.
- R2: Each trigger input pulse adds one to the trigger number modulo 2^24, so the first trigger after reset reads 0.
- R3: An ECR pulse sets the trigger number to 0xFFFFFF and adds one to the ECR count modulo 256; with a trigger in the same cycle the trigger number becomes 0 and the ECR count still advances once.
- R4: With mode bit 0 set, a trigger that takes the trigger number from 0xFFFFFF to 0 adds one to the ECR count, provided the all-ones value was reached by counting or by a host load; an all-ones value left by reset or ECR does not advance the ECR count. With mode bit 0 clear the ECR count never advances on a trigger.
- R5: The bunch counter adds one every clock and returns to 0 after 3563 when mode bit 1 is 0, or after 4095 when mode bit 1 is 1.
- R6: A BCR pulse clears the bunch counter on that clock edge; a trigger in the same cycle captures the value held before the clear.
- R7: A trigger captures (bunch counter minus offset) modulo the active period (3564 or 4096); offsets above 3563 are defined only when mode bit 1 is 1.
- R8: Host register map (word address, read value): 0 = trigger number bits 15:0; 1 = {ECR count, trigger number bits 23:16}; 2 = {offset bits 3:0 in bits 15:12, captured bunch number in bits 11:0}; 3 = offset in bits 11:0; 4 = mode in bits 1:0 (bit 0 rollover enable, bit 1 4096-period enable); other addresses read 0. Reads are combinational on the read address.
- R9: While run mode is high, host writes to address 0, to address 1 and to bits 11:0 of address 2 have no effect; while it is low they load those fields at the clock edge.
- R10: Writes to addresses 3 and 4 take effect in any mode, and bits 15:12 of a write to address 2 load offset bits 3:0 in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one cycle per bunch crossing |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | High locks the identifier words against host loads |
| trig_in | input | 1 | Trigger pulse, one cycle wide |
| ecr_in | input | 1 | Event-counter reset pulse |
| bcr_in | input | 1 | Bunch-counter reset pulse |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write word address |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 3 | Host read word address |
| rd_data | output | 16 | Host read data |
| trig_num_o | output | 24 | Current trigger number |
| ecr_cnt_o | output | 8 | Current ECR count |
| bunch_id_o | output | 12 | Offset-corrected bunch number captured by the last trigger |

## Verification
The assertions assume that trigger, ECR and BCR arrive as clean synchronous pulses and that the period and offset are changed only through host writes; properties about counter advance and capture range are therefore qualified by cycles without a host write. The range check on the captured bunch number assumes an offset below 3564 whenever the short period is active. The directed stimulus honours this by writing mode and offset first and only then issuing a BCR and a trigger a measured number of cycles later, and it never pairs a large offset with the short period.

// File: rtl/tbid_pkg.sv
package tbid_pkg;

    localparam int unsigned NUM_W    = 24;
    localparam int unsigned NUM_LO_W = 16;
    localparam int unsigned NUM_HI_W = NUM_W - NUM_LO_W;
    localparam int unsigned ECR_W    = 8;
    localparam int unsigned BX_W     = 12;
    localparam int unsigned WORD_W   = 16;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned LEG_W    = WORD_W - BX_W;
    localparam int unsigned MODE_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_NUM_LO = 3'd0,
        A_NUM_HI = 3'd1,
        A_BUNCH  = 3'd2,
        A_OFFSET = 3'd3,
        A_MODE   = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic wrap_full;
        logic roll_en;
    } mode_t;

    typedef struct packed {
        logic trig;
        logic ecr;
        logic bcr;
    } evt_t;

    typedef struct packed {
        logic              ld_lo;
        logic              ld_hi;
        logic              ld_bunch;
        logic [WORD_W-1:0] data;
    } host_ld_t;

    function automatic logic [BX_W:0] bx_period(input logic wrap_full,
                                                input int unsigned short_len);
        return wrap_full ? (BX_W+1)'(1 << BX_W) : (BX_W+1)'(short_len);
    endfunction

    function automatic logic [BX_W-1:0] bx_sub(input logic [BX_W-1:0] bx,
                                               input logic [BX_W-1:0] off,
                                               input logic [BX_W:0]   per);
        logic [BX_W:0] s;
        if (bx >= off) s = {1'b0, bx} - {1'b0, off};
        else           s = {1'b0, bx} + per - {1'b0, off};
        return s[BX_W-1:0];
    endfunction

endpackage

// File: rtl/tbid_cfg.sv
module tbid_cfg
    import tbid_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output host_ld_t          ld,
    output logic [BX_W-1:0]   offset,
    output mode_t             mode
);

    logic open_wr;

    assign open_wr     = wr_en && !run_mode;
    assign ld.ld_lo    = open_wr && (wr_addr == A_NUM_LO);
    assign ld.ld_hi    = open_wr && (wr_addr == A_NUM_HI);
    assign ld.ld_bunch = open_wr && (wr_addr == A_BUNCH);
    assign ld.data     = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            offset <= '0;
            mode   <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_OFFSET)
                offset <= wr_data[BX_W-1:0];
            else if (wr_addr == A_BUNCH)
                offset[LEG_W-1:0] <= wr_data[WORD_W-1:BX_W];
            if (wr_addr == A_MODE)
                mode <= mode_t'(wr_data[MODE_W-1:0]);
        end
    end

endmodule

// File: rtl/tbid_num_ctr.sv
module tbid_num_ctr
    import tbid_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  host_ld_t         ld,
    input  logic             roll_en,
    output logic [NUM_W-1:0] num,
    output logic [ECR_W-1:0] ecr_cnt
);

    logic             fresh;
    logic             fresh_n;
    logic             roll;
    logic [NUM_W-1:0] base_num;
    logic [NUM_W-1:0] num_n;
    logic [ECR_W-1:0] ecr_n;

    always_comb begin
        base_num = evt.ecr ? '1 : num;
        num_n    = evt.trig ? base_num + NUM_W'(1) : base_num;
        roll     = evt.trig && !evt.ecr && roll_en && !fresh && (&num);
        ecr_n    = ecr_cnt + ECR_W'(evt.ecr) + ECR_W'(roll);
        if (evt.trig)     fresh_n = 1'b0;
        else if (evt.ecr) fresh_n = 1'b1;
        else              fresh_n = fresh;
        if (ld.ld_lo) begin
            num_n[NUM_LO_W-1:0] = ld.data;
            fresh_n             = 1'b0;
        end
        if (ld.ld_hi) begin
            num_n[NUM_W-1:NUM_LO_W] = ld.data[NUM_HI_W-1:0];
            ecr_n                   = ld.data[WORD_W-1:NUM_HI_W];
            fresh_n                 = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            num     <= '1;
            ecr_cnt <= '0;
            fresh   <= 1'b1;
        end else begin
            num     <= num_n;
            ecr_cnt <= ecr_n;
            fresh   <= fresh_n;
        end
    end

endmodule

// File: rtl/tbid_bunch_ctr.sv
module tbid_bunch_ctr
    import tbid_pkg::*;
#(
    parameter int unsigned BX_SHORT = 3564
) (
    input  logic            clk,
    input  logic            rst,
    input  evt_t            evt,
    input  logic            wrap_full,
    input  logic [BX_W-1:0] offset,
    input  logic            ld_bunch,
    input  logic [BX_W-1:0] ld_data,
    output logic [BX_W-1:0] bcnt,
    output logic [BX_W-1:0] bunch_id
);

    logic [BX_W:0] period;
    logic [BX_W:0] last;

    assign period = bx_period(wrap_full, BX_SHORT);
    assign last   = period - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt     <= '0;
            bunch_id <= '0;
        end else begin
            if (evt.bcr || ({1'b0, bcnt} >= last))
                bcnt <= '0;
            else
                bcnt <= bcnt + 1'b1;
            if (ld_bunch)
                bunch_id <= ld_data;
            else if (evt.trig)
                bunch_id <= bx_sub(bcnt, offset, period);
        end
    end

endmodule

// File: rtl/tbid_top.sv
module tbid_top
    import tbid_pkg::*;
#(
    parameter int unsigned BX_SHORT = 3564
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_mode,
    input  logic              trig_in,
    input  logic              ecr_in,
    input  logic              bcr_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_W-1:0]  trig_num_o,
    output logic [ECR_W-1:0]  ecr_cnt_o,
    output logic [BX_W-1:0]   bunch_id_o
);

    evt_t             evt;
    host_ld_t         ld;
    mode_t            mode;
    logic [BX_W-1:0]  offset;
    logic [NUM_W-1:0] num;
    logic [ECR_W-1:0] ecr_cnt;
    logic [BX_W-1:0]  bcnt;
    logic [BX_W-1:0]  bunch_id;

    assign evt = '{trig: trig_in, ecr: ecr_in, bcr: bcr_in};

    tbid_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .run_mode (run_mode),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ld       (ld),
        .offset   (offset),
        .mode     (mode)
    );

    tbid_num_ctr u_num (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .ld      (ld),
        .roll_en (mode.roll_en),
        .num     (num),
        .ecr_cnt (ecr_cnt)
    );

    tbid_bunch_ctr #(.BX_SHORT(BX_SHORT)) u_bx (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .wrap_full (mode.wrap_full),
        .offset    (offset),
        .ld_bunch  (ld.ld_bunch),
        .ld_data   (ld.data[BX_W-1:0]),
        .bcnt      (bcnt),
        .bunch_id  (bunch_id)
    );

    always_comb begin
        case (rd_addr)
            A_NUM_LO: rd_data = num[NUM_LO_W-1:0];
            A_NUM_HI: rd_data = {ecr_cnt, num[NUM_W-1:NUM_LO_W]};
            A_BUNCH:  rd_data = {offset[LEG_W-1:0], bunch_id};
            A_OFFSET: rd_data = {{LEG_W{1'b0}}, offset};
            A_MODE:   rd_data = {{(WORD_W-MODE_W){1'b0}}, mode};
            default:  rd_data = '0;
        endcase
    end

    assign trig_num_o = num;
    assign ecr_cnt_o  = ecr_cnt;
    assign bunch_id_o = bunch_id;

endmodule

// File: rtl/tbid_checker.sv
module tbid_checker
    import tbid_pkg::*;
#(
    parameter int unsigned BX_SHORT = 3564
) (
    input logic             clk,
    input logic             rst,
    input logic             run_mode,
    input logic             trig_in,
    input logic             ecr_in,
    input logic             bcr_in,
    input logic             wr_en,
    input mode_t            mode,
    input logic [BX_W-1:0]  offset,
    input logic [NUM_W-1:0] num,
    input logic [ECR_W-1:0] ecr_cnt,
    input logic [BX_W-1:0]  bcnt,
    input logic [BX_W-1:0]  bunch_id
);

    logic [BX_W:0] per;
    assign per = bx_period(mode.wrap_full, BX_SHORT);

    AST_TRIG_STEP: assert property (@(posedge clk) disable iff (rst)
        trig_in && !ecr_in && run_mode |=> num == $past(num) + NUM_W'(1)); // R2

    AST_ECR_RESTART: assert property (@(posedge clk) disable iff (rst)
        ecr_in && !trig_in && run_mode |=> &num); // R3

    AST_ECR_COUNT: assert property (@(posedge clk) disable iff (rst)
        ecr_in && run_mode |=> ecr_cnt == $past(ecr_cnt) + ECR_W'(1)); // R3

    AST_RUN_LOCK: assert property (@(posedge clk) disable iff (rst)
        run_mode && !trig_in && !ecr_in |=> $stable(num) && $stable(ecr_cnt)); // R9

    AST_BX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !bcr_in && !wr_en && ({1'b0, bcnt} < per - 1'b1) |=> bcnt == $past(bcnt) + 1'b1); // R5

    AST_BX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> {1'b0, bcnt} < per); // R5

    AST_BCR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        bcr_in |=> bcnt == '0); // R6

    AST_CAPTURE_RANGE: assert property (@(posedge clk) disable iff (rst)
        trig_in && !wr_en && !mode.wrap_full && (offset < BX_W'(BX_SHORT))
        |=> bunch_id < BX_W'(BX_SHORT)); // R7

endmodule

bind tbid_top tbid_checker #(.BX_SHORT(BX_SHORT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_mode (run_mode),
    .trig_in  (trig_in),
    .ecr_in   (ecr_in),
    .bcr_in   (bcr_in),
    .wr_en    (wr_en),
    .mode     (mode),
    .offset   (offset),
    .num      (num),
    .ecr_cnt  (ecr_cnt),
    .bcnt     (bcnt),
    .bunch_id (bunch_id)
);

// File: tb/sim_tbid_top.sv
`timescale 1ns/1ps
module sim_tbid_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_mode = 1'b0;
    logic        trig_in = 1'b0;
    logic        ecr_in = 1'b0;
    logic        bcr_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [23:0] trig_num_o;
    logic [7:0]  ecr_cnt_o;
    logic [11:0] bunch_id_o;

    int vectors = 0;
    int miscmp  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    tbid_top u0 (
        .clk(clk), .rst(rst), .run_mode(run_mode),
        .trig_in(trig_in), .ecr_in(ecr_in), .bcr_in(bcr_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_num_o(trig_num_o), .ecr_cnt_o(ecr_cnt_o), .bunch_id_o(bunch_id_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic t, input logic e, input logic b);
        trig_in = t; ecr_in = e; bcr_in = b;
        @(posedge clk);
        @(negedge clk);
        trig_in = 1'b0; ecr_in = 1'b0; bcr_in = 1'b0;
    endtask

    task automatic bx_after(input int w, output logic [11:0] bx);
        logic [15:0] d;
        pulse(1'b0, 1'b0, 1'b1);
        repeat (w) @(negedge clk);
        pulse(1'b1, 1'b0, 1'b0);
        host_rd(3'd2, d);
        bx = d[11:0];
    endtask

    task automatic t_reset();
        logic [15:0] d;
        host_rd(3'd0, d); check("R1", "num lo", d, 16'hFFFF);
        host_rd(3'd1, d); check("R1", "ecr/num hi", d, 16'h00FF);
        host_rd(3'd2, d); check("R1", "bunch", d, 16'h0000);
        host_rd(3'd3, d); check("R1", "offset", d, 16'h0000);
        host_rd(3'd4, d); check("R1", "mode", d, 16'h0000);
        host_rd(3'd7, d); check("R8", "unmapped", d, 16'h0000);
    endtask

    task automatic t_trigger_count();
        pulse(1'b1, 1'b0, 1'b0);
        check("R2", "first trigger", trig_num_o, 24'h0);
        check("R4", "no roll from reset", ecr_cnt_o, 8'h0);
        pulse(1'b1, 1'b0, 1'b0);
        pulse(1'b1, 1'b0, 1'b0);
        check("R2", "third trigger", trig_num_o, 24'h2);
    endtask

    task automatic t_ecr();
        logic [15:0] d;
        pulse(1'b0, 1'b1, 1'b0);
        check("R3", "ecr num", trig_num_o, 24'hFFFFFF);
        check("R3", "ecr count", ecr_cnt_o, 8'h1);
        pulse(1'b1, 1'b1, 1'b0);
        check("R3", "ecr+trig num", trig_num_o, 24'h0);
        check("R3", "ecr+trig count", ecr_cnt_o, 8'h2);
        host_wr(3'd1, 16'hFF00);
        pulse(1'b0, 1'b1, 1'b0);
        check("R3", "ecr count wrap", ecr_cnt_o, 8'h0);
        host_rd(3'd1, d);
        check("R8", "hi word layout", d, 16'h00FF);
    endtask

    task automatic t_rollover();
        host_wr(3'd4, 16'h0001);
        host_wr(3'd0, 16'hFFFF);
        host_wr(3'd1, 16'h05FF);
        pulse(1'b1, 1'b0, 1'b0);
        check("R4", "roll num", trig_num_o, 24'h0);
        check("R4", "roll ecr", ecr_cnt_o, 8'h6);
        pulse(1'b0, 1'b1, 1'b0);
        pulse(1'b1, 1'b0, 1'b0);
        check("R4", "no roll after ecr", ecr_cnt_o, 8'h7);
        host_wr(3'd4, 16'h0000);
        host_wr(3'd0, 16'hFFFF);
        host_wr(3'd1, 16'h03FF);
        pulse(1'b1, 1'b0, 1'b0);
        check("R4", "roll disabled", ecr_cnt_o, 8'h3);
    endtask

    task automatic t_bunch_wrap();
        logic [11:0] bx;
        host_wr(3'd3, 16'h0000);
        host_wr(3'd4, 16'h0000);
        bx_after(3563, bx); check("R5", "short last", bx, 12'd3563);
        bx_after(3564, bx); check("R5", "short wrap", bx, 12'd0);
        host_wr(3'd4, 16'h0002);
        bx_after(3564, bx); check("R5", "full past 3563", bx, 12'd3564);
        bx_after(4095, bx); check("R5", "full last", bx, 12'd4095);
        bx_after(4096, bx); check("R5", "full wrap", bx, 12'd0);
        host_wr(3'd4, 16'h0000);
    endtask

    task automatic t_bcr_same();
        logic [15:0] d;
        pulse(1'b0, 1'b0, 1'b1);
        repeat (100) @(negedge clk);
        pulse(1'b1, 1'b0, 1'b1);
        check("R6", "pre-clear capture", bunch_id_o, 12'd100);
        repeat (7) @(negedge clk);
        pulse(1'b1, 1'b0, 1'b0);
        host_rd(3'd2, d);
        check("R6", "count after clear", d[11:0], 12'd7);
    endtask

    task automatic t_offset();
        logic [11:0] bx;
        host_wr(3'd3, 16'd10);
        bx_after(5, bx);  check("R7", "short underflow", bx, 12'd3559);
        bx_after(20, bx); check("R7", "short plain", bx, 12'd10);
        host_wr(3'd4, 16'h0002);
        bx_after(5, bx);  check("R7", "full underflow", bx, 12'd4091);
        host_wr(3'd3, 16'd4000);
        bx_after(100, bx); check("R7", "large offset", bx, 12'd196);
        host_wr(3'd3, 16'd0);
        host_wr(3'd4, 16'h0000);
    endtask

    task automatic t_run_lock();
        logic [15:0] d;
        logic [15:0] lo0, hi0, bx0;
        host_rd(3'd0, lo0);
        host_rd(3'd1, hi0);
        host_rd(3'd2, bx0);
        run_mode = 1'b1;
        host_wr(3'd0, 16'h1234);
        host_rd(3'd0, d); check("R9", "lo locked", d, lo0);
        host_wr(3'd1, 16'h4321);
        host_rd(3'd1, d); check("R9", "hi locked", d, hi0);
        host_wr(3'd2, 16'h5ABC);
        host_rd(3'd2, d); check("R9", "bunch locked", d[11:0], bx0[11:0]);
        check("R10", "legacy nibble in run", d[15:12], 4'h5);
        host_rd(3'd3, d); check("R10", "offset via legacy", d, 16'h0005);
        host_wr(3'd3, 16'h0ABC);
        host_rd(3'd3, d); check("R10", "offset in run", d, 16'h0ABC);
        host_wr(3'd4, 16'h0003);
        host_rd(3'd4, d); check("R10", "mode in run", d, 16'h0003);
        run_mode = 1'b0;
        host_wr(3'd0, 16'h1234);
        host_rd(3'd0, d); check("R9", "lo open", d, 16'h1234);
        host_wr(3'd2, 16'h0123);
        host_rd(3'd2, d); check("R9", "bunch open", d, 16'h0123);
        host_wr(3'd3, 16'h0000);
        host_wr(3'd4, 16'h0000);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_trigger_count();
        t_ecr();
        t_rollover();
        t_bunch_wrap();
        t_bcr_same();
        t_offset();
        t_run_lock();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscmp++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

endmodule